// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. Reset starts it. It first waits out a long power-up pause. It then runs a fixed number of warm-up refresh cycles and raises `ready`. After that it refreshes at a steady rate: a slot timer marks one refresh slot every `INTERVAL_CYC` clocks. Each slot adds one to a bounded backlog, and the backlog is paid off whenever the memory controller lends the device pins to the sequencer.

The controller and the sequencer share the pins through a plain request/grant pair. The sequencer raises `refresh_req` when refresh work is pending. A cycle starts only on a clock where both `refresh_req` and `refresh_gnt` are high. From that edge until `refresh_req` falls, the sequencer drives the strobes and the controller must keep `refresh_gnt` high. While the grant is low and no cycle is running, the strobes stay idle and the backlog grows, up to a limit. If a slot arrives while the backlog is full, a sticky overflow flag is set. It clears only on reset.

The default cycle is CAS-before-RAS: the device's internal row counter picks the row, and the write strobe stays high so the cycle cannot be taken as a test-mode entry. Setting the parameter `RAS_ONLY` selects the other variant. In that variant CAS stays high, and the block drives its own row address, which steps by one after every cycle. All timings are parameters in clock cycles. The defaults assume a 5 ns clock, 4096 rows refreshed per 64 ms, and a 200 µs pause.

Top module: `dram_refresh_seq`

## Requirements
- R1: `refresh_req` stays low and `ras_n` stays high for exactly `PAUSE_CYC` clock edges after reset is released. `refresh_req` is first high after edge number `PAUSE_CYC`.
- R2: `ready` stays low while exactly `INIT_REFRESHES` refresh cycles complete, and rises in the clock after the last of them ends.
- R3: Slots are not counted before `ready`. The first slot request appears `INTERVAL_CYC` clocks after `ready` rises. After that, slots are `INTERVAL_CYC` clocks apart.
- R4: A refresh cycle starts only when `refresh_req` and `refresh_gnt` are both high. While the grant is low and no cycle runs, `ras_n` does not fall.
- R5: Each slot adds one to the backlog, up to `BACKLOG_MAX`. When the grant is then given, exactly min(slots, `BACKLOG_MAX`) cycles run before `refresh_req` drops.
- R6: `backlog_overflow` is set when a slot arrives with the backlog full and no cycle starting in that clock. Once set, it stays set until reset.
- R7: In CAS-before-RAS mode, `cas_n` (active low) falls exactly `T_CSR` clocks before `ras_n` falls. It stays low for `T_CSR+T_CHR` clocks in total.
- R8: `ras_n` is low for exactly `T_RAS` clocks per cycle. Between cycles it is high for at least `T_RP` clocks.
- R9: `we_n` is high whenever `ras_n` falls.
- R10: In RAS-only mode, `cas_n` stays high. `row_addr_oe` is high from the clock before `ras_n` falls and through the low phase, and `row_addr` is stable while `ras_n` is low. The row starts at 0 and goes up by one after each cycle, modulo 2^`ROW_BITS`.
- R11: During reset, `ras_n`, `cas_n` and `we_n` are high, and `refresh_req`, `ready`, `backlog_overflow` and `row_addr_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_gnt | input | 1 | Controller lends the DRAM pins to the sequencer |
| refresh_req | output | 1 | Refresh work pending or a cycle in progress |
| ready | output | 1 | Power-up sequence finished |
| backlog_overflow | output | 1 | Sticky: a slot was lost with the backlog full |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_BITS | Row for RAS-only refresh, zero otherwise |
| row_addr_oe | output | 1 | Drive enable for `row_addr` |

## Verification
The assertions check on every clock the local rules of each cycle:
- the CAS lead before RAS falls;
- the exact RAS low width;
- the slot spacing;
- that a cycle starts only under a grant;
- that the overflow flag is sticky;
- that the row address is stable and driven in RAS-only mode.

Other behaviours span many cycles and only the bench's scenarios can show them: the length of the pause, the exact number of warm-up cycles, that slots are ignored before `ready`, the backlog drain count for each withheld-grant length, and the row wrap.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
  typedef enum logic [1:0] {CY_IDLE, CY_SETUP, CY_ACT, CY_PRE} cyc_e;
endpackage

// File: rtl/drs_init_ctrl.sv
module drs_init_ctrl
  import drs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC      = 40000,
  parameter int unsigned INIT_REFRESHES = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_done,
  output phase_e phase,
  output logic   init_need
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned IW = $clog2(INIT_REFRESHES + 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] left_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pause_cnt <= PW'(PAUSE_CYC - 1);
      left_cnt  <= IW'(INIT_REFRESHES);
    end else begin
      unique case (phase)
        PH_PAUSE: begin
          if (pause_cnt == '0) phase <= PH_INIT;
          else                 pause_cnt <= pause_cnt - 1'b1;
        end
        PH_INIT: begin
          if (cyc_done) begin
            left_cnt <= left_cnt - 1'b1;
            if (left_cnt == IW'(1)) phase <= PH_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign init_need = (phase == PH_INIT) && (left_cnt != '0);

  // R2
  init_exit_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) != PH_RUN) |-> $past(cyc_done));
endmodule

// File: rtl/drs_slot_timer.sv
module drs_slot_timer #(
  parameter int unsigned INTERVAL_CYC = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned TW = $clog2(INTERVAL_CYC);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= TW'(INTERVAL_CYC - 1);
    else if (!en)          cnt <= TW'(INTERVAL_CYC - 1);
    else if (cnt == '0)    cnt <= TW'(INTERVAL_CYC - 1);
    else                   cnt <= cnt - 1'b1;
  end

  assign tick = en && (cnt == '0);

  // Independent gap counter used only by the check below.
  logic [TW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap <= '0;
    else if (!en)      gap <= '0;
    else if (tick)     gap <= '0;
    else               gap <= gap + 1'b1;
  end

  // R3
  slot_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == TW'(INTERVAL_CYC - 1)));
endmodule

// File: rtl/drs_backlog.sv
module drs_backlog #(
  parameter int unsigned BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pending,
  output logic overflow
);
  localparam int unsigned CW = $clog2(BACKLOG_MAX + 1);

  logic [CW-1:0] cnt;
  logic          full, inc;

  assign full = (cnt == CW'(BACKLOG_MAX));
  assign inc  = tick && (!full || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      unique case ({inc, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
      if (tick && full && !take) overflow <= 1'b1;
    end
  end

  assign pending = (cnt != '0);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(cnt) == CW'(BACKLOG_MAX)) && $past(tick));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);
endmodule

// File: rtl/drs_cycle_fsm.sv
module drs_cycle_fsm
  import drs_pkg::*;
#(
  parameter int unsigned T_CSR    = 1,
  parameter int unsigned T_CHR    = 2,
  parameter int unsigned T_RAS    = 12,
  parameter int unsigned T_RP     = 8,
  parameter bit          RAS_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic start,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic addr_oe
);
  localparam int unsigned TMAX0 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int unsigned TMAX  = (TMAX0 > T_RP) ? TMAX0 : T_RP;
  localparam int unsigned TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] CHR_LIM = TW'(T_RAS - T_CHR);

  cyc_e          st, nst;
  logic [TW-1:0] tmr, ntm;
  logic          cas_low_nxt;

  always_comb begin
    nst   = st;
    ntm   = tmr;
    start = 1'b0;
    done  = 1'b0;
    unique case (st)
      CY_IDLE: if (go) begin
        nst   = CY_SETUP;
        ntm   = TW'(T_CSR - 1);
        start = 1'b1;
      end
      CY_SETUP: if (tmr == '0) begin
        nst = CY_ACT;
        ntm = TW'(T_RAS - 1);
      end else ntm = tmr - 1'b1;
      CY_ACT: if (tmr == '0) begin
        nst = CY_PRE;
        ntm = TW'(T_RP - 1);
      end else ntm = tmr - 1'b1;
      CY_PRE: if (tmr == '0) begin
        nst  = CY_IDLE;
        done = 1'b1;
      end else ntm = tmr - 1'b1;
      default: nst = CY_IDLE;
    endcase
  end

  assign cas_low_nxt = !RAS_ONLY &&
                       ((nst == CY_SETUP) || (nst == CY_ACT && ntm >= CHR_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CY_IDLE;
      tmr     <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      addr_oe <= 1'b0;
    end else begin
      st      <= nst;
      tmr     <= ntm;
      ras_n   <= (nst != CY_ACT);
      cas_n   <= !cas_low_nxt;
      addr_oe <= RAS_ONLY && (nst == CY_SETUP || nst == CY_ACT);
    end
  end

  assign busy = (st != CY_IDLE);
  assign we_n = 1'b1;

  // Low-width counter used only by the check below.
  logic [TW:0] lo_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_len <= '0;
    else if (ras_n) lo_len <= '0;
    else            lo_len <= lo_len + 1'b1;
  end

  // R8
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_len == (TW+1)'(T_RAS)));

  generate
    if (!RAS_ONLY) begin : g_cbr_chk
      // R7
      cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC      = 40000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned INTERVAL_CYC   = 3120,
  parameter int unsigned BACKLOG_MAX    = 8,
  parameter int unsigned T_CSR          = 1,
  parameter int unsigned T_CHR          = 2,
  parameter int unsigned T_RAS          = 12,
  parameter int unsigned T_RP           = 8,
  parameter int unsigned ROW_BITS       = 12,
  parameter bit          RAS_ONLY       = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh_gnt,
  output logic                refresh_req,
  output logic                ready,
  output logic                backlog_overflow,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                row_addr_oe
);
  phase_e phase;
  logic   init_need, slot_tick, pending;
  logic   cyc_busy, cyc_start, cyc_done;
  logic   need, go, take, run;

  assign run         = (phase == PH_RUN);
  assign need        = init_need || (run && pending);
  assign go          = need && refresh_gnt;
  assign take        = cyc_start && run;
  assign refresh_req = cyc_busy || need;
  assign ready       = run;

  drs_init_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_REFRESHES(INIT_REFRESHES)
  ) u_init (
    .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done),
    .phase(phase), .init_need(init_need)
  );

  drs_slot_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_slot (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(slot_tick)
  );

  drs_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(slot_tick), .take(take),
    .pending(pending), .overflow(backlog_overflow)
  );

  drs_cycle_fsm #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .RAS_ONLY(RAS_ONLY)
  ) u_cyc (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(cyc_busy), .start(cyc_start),
    .done(cyc_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr_oe(row_addr_oe)
  );

  generate
    if (RAS_ONLY) begin : g_row
      logic [ROW_BITS-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        row_q <= '0;
        else if (cyc_done) row_q <= row_q + 1'b1;
      end
      assign row_addr = row_q;

      // R10
      row_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (row_addr_oe && $past(row_addr_oe) && cas_n));
      // R10
      row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> $stable(row_addr));
    end else begin : g_norow
      assign row_addr = '0;
    end
  endgenerate

  // R4
  start_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && !$past(cyc_busy)) |-> ($past(refresh_gnt) && $past(refresh_req)));
  // R9
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> we_n);
endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int PAUSE = 20;
  localparam int NINIT = 8;
  localparam int IVL   = 100;
  localparam int BMAX  = 3;
  localparam int TCSR  = 1;
  localparam int TCHR  = 2;
  localparam int TRAS  = 6;
  localparam int TRP   = 4;
  localparam int RB    = 3;

  localparam int NV = 6;
  localparam int VEC_K  [NV] = '{1, 2, 3, 4, 2, 6};
  localparam int VEC_N  [NV] = '{1, 2, 3, 3, 2, 3};
  localparam int VEC_OV [NV] = '{0, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, rdy, ovf, ras_n, cas_n, we_n, oe;
  logic [RB-1:0] row;
  logic req2, rdy2, ovf2, ras2_n, cas2_n, we2_n, oe2;
  logic [RB-1:0] row2;

  int nchk = 0;
  int nfail = 0;
  int cbr_falls = 0;
  int ro_falls = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_REFRESHES(NINIT), .INTERVAL_CYC(IVL),
    .BACKLOG_MAX(BMAX), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP),
    .ROW_BITS(RB), .RAS_ONLY(1'b0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(gnt), .refresh_req(req),
    .ready(rdy), .backlog_overflow(ovf), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row), .row_addr_oe(oe)
  );

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_REFRESHES(NINIT), .INTERVAL_CYC(IVL),
    .BACKLOG_MAX(BMAX), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP),
    .ROW_BITS(RB), .RAS_ONLY(1'b1)
  ) dut_ro (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(1'b1), .refresh_req(req2),
    .ready(rdy2), .backlog_overflow(ovf2), .ras_n(ras2_n), .cas_n(cas2_n),
    .we_n(we2_n), .row_addr(row2), .row_addr_oe(oe2)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Strobe-timing monitor for the CAS-before-RAS instance (R7, R8, R9)
  int  m_cas_lo = 0, m_ras_lo = 0, m_ras_hi = 1000;
  bit  m_pras = 1'b1, m_pcas = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_pras && !ras_n) begin
        cbr_falls++;
        chk(m_cas_lo == TCSR, "R7 cas lead", m_cas_lo, TCSR);
        chk(we_n == 1'b1, "R9 we high", we_n, 1);
        chk(m_ras_hi >= TRP, "R8 precharge", m_ras_hi, TRP);
      end
      if (!m_pras && ras_n) chk(m_ras_lo == TRAS, "R8 ras width", m_ras_lo, TRAS);
      if (!m_pcas && cas_n)
        chk(m_cas_lo == TCSR + TCHR, "R7 cas hold", m_cas_lo, TCSR + TCHR);
      m_cas_lo = cas_n ? 0 : m_cas_lo + 1;
      m_ras_lo = ras_n ? 0 : m_ras_lo + 1;
      m_ras_hi = ras_n ? m_ras_hi + 1 : 0;
      m_pras = ras_n;
      m_pcas = cas_n;
    end
  end

  // Row monitor for the RAS-only instance (R10)
  bit m2_pras = 1'b1, m2_poe = 1'b0;
  int m2_row = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m2_pras && !ras2_n) begin
        ro_falls++;
        chk(int'(row2) == m2_row, "R10 row value", int'(row2), m2_row);
        chk(cas2_n && oe2 && m2_poe, "R10 cas high and address driven",
            int'({cas2_n, oe2, m2_poe}), 7);
        m2_row = (m2_row + 1) % (1 << RB);
      end
      if (!m2_pras && ras2_n) chk(cas2_n == 1'b1, "R10 cas high", cas2_n, 1);
      m2_pras = ras2_n;
      m2_poe  = oe2;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int n, f0, ov_exp;
    repeat (3) step();
    // R11 reset state
    chk(ras_n && cas_n && we_n, "R11 strobes idle", int'({ras_n, cas_n, we_n}), 7);
    chk(!req && !rdy && !ovf && !oe2, "R11 outputs low",
        int'({req, rdy, ovf, oe2}), 0);
    rst_n = 1'b1;

    // R1 pause length
    n = 0;
    while (!req && n < 10 * PAUSE) begin step(); n++; end
    chk(n == PAUSE, "R1 pause length", n, PAUSE);
    chk(cbr_falls == 0, "R1 no refresh during pause", cbr_falls, 0);

    // R4 / R3: grant withheld during init; slots must not accumulate
    repeat (3 * IVL) step();
    chk(cbr_falls == 0, "R4 no cycle without grant", cbr_falls, 0);
    chk(!rdy, "R2 ready low before init", rdy, 0);
    gnt = 1'b1;
    n = 0;
    while (!rdy && n < 2000) begin step(); n++; end
    gnt = 1'b0;
    chk(cbr_falls == NINIT, "R2 init refresh count", cbr_falls, NINIT);

    // R3 first slot one interval after ready
    n = 0;
    while (!req && n < 10 * IVL) begin step(); n++; end
    chk(n == IVL, "R3 first slot delay", n, IVL);

    // R5 / R6 vector table: withhold grant for K slots, then drain
    ov_exp = 0;
    for (int v = 0; v < NV; v++) begin
      n = 0;
      while (!req && n < 10 * IVL) begin step(); n++; end
      f0 = cbr_falls;
      repeat ((VEC_K[v] - 1) * IVL + IVL / 2) step();
      chk(cbr_falls == f0, "R4 idle while grant low", cbr_falls - f0, 0);
      gnt = 1'b1;
      n = 0;
      while (req && n < IVL) begin step(); n++; end
      gnt = 1'b0;
      chk(cbr_falls - f0 == VEC_N[v], "R5 drained count", cbr_falls - f0, VEC_N[v]);
      if (VEC_K[v] > BMAX) ov_exp = 1;
      chk(int'(ovf) == VEC_OV[v] && VEC_OV[v] == ov_exp, "R6 overflow flag",
          int'(ovf), VEC_OV[v]);
    end

    // R3 steady spacing with grant always given
    gnt = 1'b1;
    begin
      int t_prev, t_now, k;
      k = 0; t_prev = 0; n = 0;
      f0 = cbr_falls;
      while (k < 3 && n < 10 * IVL) begin
        step(); n++;
        if (cbr_falls != f0) begin
          f0 = cbr_falls;
          t_now = n;
          if (k > 0) chk(t_now - t_prev == IVL, "R3 slot spacing", t_now - t_prev, IVL);
          t_prev = t_now;
          k++;
        end
      end
      chk(k == 3, "R3 periodic refresh seen", k, 3);
    end

    // R10 wrap coverage for the RAS-only instance
    chk(ro_falls > (1 << RB), "R10 row wrap exercised", ro_falls, (1 << RB) + 1);
    chk(ovf2 == 1'b0, "R6 no overflow when always granted", ovf2, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule